// File: doc/BRIEF.md
# Packed-Nibble Frame Buffer Video Output

This block turns a raster position into a pixel colour. The frame buffer is organised by column. Each byte holds two horizontally adjacent 4-bit pixels, and the low part of the byte address selects the row. On every pixel clock the display side presents a horizontal position and a vertical position. The block reads the byte that covers that position from an internal synchronous RAM and picks the correct nibble. It then uses that nibble to index a file of sixteen 8-bit colour registers. The selected colour byte is expanded to 24-bit RGB through fixed weights that are not powers of two.

The processor side has two independent byte write ports. One writes into the frame buffer and the other writes into the colour registers. Rows outside a fixed visible window, and horizontal positions past the displayed width, come out black with the visible flag low. In the full-size arrangement there are 8 column bits, 240 visible rows and a width of 304 pixels. The defaults are reduced to 8 byte columns so that the RAM stays small.

Top module: `nibscan_top`

## Requirements
- R1: The frame buffer byte read for position (h, v) is at address {h[COL_BITS:1], v}, so the row occupies the low 8 address bits and the byte column the bits above.
- R2: An even h shows the high nibble (bits 7:4) of that byte and an odd h shows the low nibble (bits 3:0).
- R3: A colour register value packs red in bits 2:0, green in bits 5:3 and blue in bits 7:6. Red and green each expand to 8 bits as 33·bit0 + 71·bit1 + 151·bit2 of their field.
- R4: Blue expands as 71·bit6 + 151·bit7. rgb_out carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: vis_out is 1 exactly when the sampled v lies in 6..245 inclusive and h is below H_PIXELS.
- R6: Whenever vis_out is 0, rgb_out is 0.
- R7: Positions presented before clock edge k appear on rgb_out and vis_out after edge k+1, which is two cycles of latency. A new pixel is produced on every cycle.
- R8: A colour register write taken at edge k is used by the output registered at edge k+1. The output registered at edge k still uses the old value.
- R9: When the frame buffer is written at the address that the scan reads in the same cycle, the scan gets the old byte. The write still lands, and the next read returns the new byte.
- R10: During and right after reset, rgb_out and vis_out are 0 and all colour registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_we | input | 1 | Frame buffer byte write enable |
| fb_waddr | input | COL_BITS+ROW_BITS | Frame buffer write address {column, row} |
| fb_wdata | input | 8 | Two packed pixels to write |
| clut_we | input | 1 | Colour register write enable |
| clut_waddr | input | 4 | Colour register index |
| clut_wdata | input | 8 | Colour byte, blue/green/red packed |
| h_pos | input | COL_BITS+2 | Horizontal pixel position |
| v_pos | input | ROW_BITS | Vertical position (row) |
| rgb_out | output | 24 | Expanded colour {R,G,B} |
| vis_out | output | 1 | Pixel lies in the displayed area |

## Verification
The bench checks the vertical window edges at rows 5, 6, 245 and 246, and positions just past the displayed width. A window comparison that is off by one would show or hide a whole line, or leak colour into blanking. It alternates even and odd h over bytes whose two nibbles differ, so swapping the nibbles or taking the column from the wrong bits gives visibly wrong colours. It writes colour registers and frame buffer bytes in the same cycle as the scan uses them. A design that forwarded the new byte, or delayed the palette update by one cycle, would then show a single wrong pixel. Colour values with lone bits set catch a misplaced expansion weight or a field that has been moved.

// File: rtl/nibscan_pkg.sv
package nibscan_pkg;

    localparam int PIX_W      = 4;
    localparam int CLUT_DEPTH = 1 << PIX_W;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

endpackage

// File: rtl/nibscan_ram.sv
module nibscan_ram #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] rdata_q;

    // Read returns the pre-write contents on a same-address collision.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R9

    AST_RD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr == raddr) && (wdata != mem[raddr])) |=> (rdata != $past(wdata))); // R9

endmodule

// File: rtl/nibscan_clut.sv
module nibscan_clut
    import nibscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PIX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PIX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] regs_d [CLUT_DEPTH];
    logic [7:0] regs_q [CLUT_DEPTH];

    always_comb begin
        for (int i = 0; i < CLUT_DEPTH; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    generate
        for (genvar g = 0; g < CLUT_DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                end else begin
                    regs_q[g] <= regs_d[g];
                end
            end
        end
    endgenerate

    assign rdata = regs_q[raddr];

    AST_CLUT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs_q[$past(waddr)] == $past(wdata))); // R8

endmodule

// File: rtl/nibscan_expand.sv
module nibscan_expand
    import nibscan_pkg::*;
(
    input  logic [7:0] colour,
    output rgb_t       rgb
);
    function automatic logic [7:0] weigh3(input logic [2:0] f);
        logic [7:0] s;
        s = 8'd0;
        if (f[0]) s = s + 8'd33;
        if (f[1]) s = s + 8'd71;
        if (f[2]) s = s + 8'd151;
        return s;
    endfunction

    always_comb begin
        rgb.r = weigh3(colour[2:0]);
        rgb.g = weigh3(colour[5:3]);
        rgb.b = weigh3({colour[7:6], 1'b0});
    end

endmodule

// File: rtl/nibscan_top.sv
module nibscan_top
    import nibscan_pkg::*;
#(
    parameter int COL_BITS      = 3,
    parameter int ROW_BITS      = 8,
    parameter int VIS_FIRST_ROW = 6,
    parameter int VIS_LAST_ROW  = 245,
    parameter int H_PIXELS      = 2 ** (COL_BITS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fb_we,
    input  logic [COL_BITS+ROW_BITS-1:0] fb_waddr,
    input  logic [7:0]                   fb_wdata,
    input  logic                         clut_we,
    input  logic [3:0]                   clut_waddr,
    input  logic [7:0]                   clut_wdata,
    input  logic [COL_BITS+1:0]          h_pos,
    input  logic [ROW_BITS-1:0]          v_pos,
    output logic [23:0]                  rgb_out,
    output logic                         vis_out
);
    localparam int ADDR_W = COL_BITS + ROW_BITS;
    localparam int H_W    = COL_BITS + 2;
    localparam logic [ROW_BITS-1:0] VF = ROW_BITS'(VIS_FIRST_ROW);
    localparam logic [ROW_BITS-1:0] VL = ROW_BITS'(VIS_LAST_ROW);
    localparam logic [H_W-1:0]      HP = H_W'(H_PIXELS);

    typedef struct packed {
        logic vis1;   // fetch stage: window flag
        logic odd1;   // fetch stage: right pixel of the byte
        logic vis2;   // output stage
        rgb_t rgb;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_byte;
    logic [PIX_W-1:0]  nib;
    logic [7:0]        colour;
    rgb_t              expanded;
    logic              in_window;

    assign rd_addr   = {h_pos[COL_BITS:1], v_pos};
    assign in_window = (v_pos >= VF) && (v_pos <= VL) && (h_pos < HP);

    nibscan_ram #(.ADDR_W(ADDR_W)) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fb_we),
        .waddr (fb_waddr),
        .wdata (fb_wdata),
        .raddr (rd_addr),
        .rdata (rd_byte)
    );

    assign nib = pipe_q.odd1 ? rd_byte[3:0] : rd_byte[7:4];

    nibscan_clut i_clut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (clut_we),
        .waddr (clut_waddr),
        .wdata (clut_wdata),
        .raddr (nib),
        .rdata (colour)
    );

    nibscan_expand i_expand (
        .colour (colour),
        .rgb    (expanded)
    );

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.vis1 = in_window;
        pipe_d.odd1 = h_pos[0];
        pipe_d.vis2 = pipe_q.vis1;
        pipe_d.rgb  = pipe_q.vis1 ? expanded : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign rgb_out = pipe_q.rgb;
    assign vis_out = pipe_q.vis2;

    AST_VIS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        vis_out |-> (($past(v_pos, 2) >= VF) && ($past(v_pos, 2) <= VL) && ($past(h_pos, 2) < HP))); // R5

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_out |-> (rgb_out == 24'd0)); // R6

    AST_VIS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vis_out) |-> $past(in_window, 2)); // R7

endmodule

// File: tb/test_nibscan_top.sv
`timescale 1ns/1ps
module test_nibscan_top;
    localparam int COLB  = 3;
    localparam int ROWB  = 8;
    localparam int NCOL  = 1 << COLB;
    localparam int DEPTH = NCOL * 256;
    localparam int HPIX  = 2 * NCOL;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 fb_we = 1'b0;
    logic [COLB+ROWB-1:0] fb_waddr = '0;
    logic [7:0]           fb_wdata = '0;
    logic                 clut_we = 1'b0;
    logic [3:0]           clut_waddr = '0;
    logic [7:0]           clut_wdata = '0;
    logic [COLB+1:0]      h_pos = '0;
    logic [ROWB-1:0]      v_pos = '0;
    logic [23:0]          rgb_out;
    logic                 vis_out;

    always #2.5 clk = ~clk;

    nibscan_top i_nibscan_top (
        .clk(clk), .rst_n(rst_n),
        .fb_we(fb_we), .fb_waddr(fb_waddr), .fb_wdata(fb_wdata),
        .clut_we(clut_we), .clut_waddr(clut_waddr), .clut_wdata(clut_wdata),
        .h_pos(h_pos), .v_pos(v_pos),
        .rgb_out(rgb_out), .vis_out(vis_out)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string phase = "R10";

    // behavioural reference state
    int fbm [DEPTH];
    int pal [16];
    int s1_byte = 0;
    int s1_odd = 0;
    bit s1_vis = 0;
    bit exp_vis = 0;
    int exp_rgb = 0;

    function automatic int chan(int lo, int mid, int hi);
        return 33 * lo + 71 * mid + 151 * hi;
    endfunction

    function automatic int to_rgb(int c);
        int r, g, b;
        r = chan(c & 1, (c >> 1) & 1, (c >> 2) & 1);
        g = chan((c >> 3) & 1, (c >> 4) & 1, (c >> 5) & 1);
        b = chan(0, (c >> 6) & 1, (c >> 7) & 1);
        return (r << 16) | (g << 8) | b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            s1_vis = 0; s1_odd = 0; exp_vis = 0; exp_rgb = 0;
            for (int i = 0; i < 16; i++) pal[i] = 0;
        end else begin
            int nb, a, h, v;
            nb = (s1_odd != 0) ? (s1_byte & 15) : ((s1_byte >> 4) & 15);
            exp_vis = s1_vis;
            exp_rgb = s1_vis ? to_rgb(pal[nb]) : 0;
            h = int'(h_pos); v = int'(v_pos);
            a = ((h / 2) % NCOL) * 256 + v;
            s1_byte = fbm[a];
            s1_odd = h % 2;
            s1_vis = (v >= 6) && (v <= 245) && (h < HPIX);
            if (fb_we) fbm[int'(fb_waddr)] = int'(fb_wdata);
            if (clut_we) pal[int'(clut_waddr)] = int'(clut_wdata);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (int'(rgb_out) != exp_rgb || vis_out != exp_vis) begin
                n_bad++;
                $display("FAIL %s: rgb=%06h vis=%0b expected rgb=%06h vis=%0b at h=%0d v=%0d",
                         (vis_out != exp_vis) ? "R5" : (!exp_vis ? "R6" : phase),
                         rgb_out, vis_out, exp_rgb[23:0], exp_vis, h_pos, v_pos);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic scan(int v, int h0, int h1);
        for (int h = h0; h <= h1; h++) begin
            @(negedge clk);
            v_pos = ROWB'(v);
            h_pos = (COLB+2)'(h);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        int rows [8] = '{0, 5, 6, 7, 100, 245, 246, 255};
        // R10: outputs quiet under reset
        repeat (3) @(negedge clk);
        n_cmp++;
        if (rgb_out !== 24'd0 || vis_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: rgb=%06h vis=%0b expected rgb=000000 vis=0", rgb_out, vis_out);
        end
        @(negedge clk); rst_n = 1'b1;
        // fill frame buffer, two distinct nibbles per byte (R1, R2)
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            fb_we = 1'b1;
            fb_waddr = (COLB+ROWB)'(a);
            fb_wdata = 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
        end
        @(negedge clk); fb_we = 1'b0;
        // R10: palette cleared, visible pixels black
        phase = "R10";
        scan(50, 0, 15);
        // R3 R4: program lone-bit and mixed colours
        phase = "R3";
        for (int i = 0; i < 16; i++) begin
            int cv [16] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80,
                            8'hFF, 8'h07, 8'h38, 8'hC0, 8'h49, 8'hB6, 8'h5A, 8'h93};
            @(negedge clk);
            clut_we = 1'b1; clut_waddr = 4'(i); clut_wdata = 8'(cv[i]);
        end
        @(negedge clk); clut_we = 1'b0;
        // R1 R2 R4 R5 R7: raster sweep across window edges and past the width
        phase = "R1/R2/R4/R7";
        for (int k = 0; k < 8; k++) scan(rows[k], 0, HPIX + 5);
        // R8: palette rewritten while one pixel is held
        phase = "R8";
        scan(120, 3, 3);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            clut_we = 1'b1; clut_waddr = 4'(i); clut_wdata = 8'((i * 29 + 3) & 255);
            h_pos = (COLB+2)'(i % HPIX);
        end
        @(negedge clk); clut_we = 1'b0;
        scan(120, 0, 15);
        // R9: write the byte being scanned in the same cycle
        phase = "R9";
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            v_pos = 8'(10 + k); h_pos = (COLB+2)'(4 + (k % 2));
            fb_we = 1'b1;
            fb_waddr = (COLB+ROWB)'(2 * 256 + 10 + k);
            fb_wdata = 8'(8'hA5 ^ (k * 17));
        end
        @(negedge clk); fb_we = 1'b0;
        for (int k = 0; k < 6; k++) scan(10 + k, 4, 5);
        phase = "R1/R2/R7";
        scan(200, 0, 19);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule